// File: doc/BRIEF.md
# Instruction TLB with LRU Refill

This block is a four-entry, fully associative translation buffer for instruction fetches. Each lookup carries a virtual address, a flag that turns on address-space-identifier (ASID) checking, the current ASID, the privilege level of the fetch and an update enable. An entry covers a page of 1 KB, 4 KB, 64 KB or 1 MB. The block answers with a hit index and a translated physical address, or with a miss, multiple-hit or protection-violation status.

When a lookup misses and the update enable is set, the block asks the shared (unified) TLB for the same address. It then waits for the reply. A reply that carries an entry is copied into a victim slot and answered as a hit. A reply that reports a miss or a multiple hit is passed on as it stands. The victim slot comes from a 6-bit pairwise-order LRU code. This code sits in the top six bits of the MMU control register. The block reads that register on an input port and returns the updated value on an output port with a write strobe. The owner of the register decides when to store the value.

Top module: `itlb_refill`

## Requirements
- R1: During and right after reset, every entry is invalid, `lk_ready` is 1, and `res_valid`, `ut_req` and `mmucr_we` are 0.
- R2: An entry matches when it is valid and the lookup address, with the page-offset bits cleared, equals the entry's `vpn` shifted left by 10 with the same bits cleared. The page size code is 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. A single match gives `res_status` 0 (OK) one cycle after acceptance, with the entry index. `res_paddr` is the entry's `ppn` shifted left by 10 with the offset bits taken from the lookup address.
- R3: When `lk_use_asid` is 1, a non-shared entry matches only if its ASID equals `cur_asid`. Shared entries, and all lookups with `lk_use_asid` 0, ignore the ASID.
- R4: Two or more matches give `res_status` 2 (MULTI) with index and address 0, and no control-register write. A unified-TLB reply of code 2 also gives MULTI.
- R5: A privileged fetch (`lk_priv` 1) that hits an entry whose `prot[1]` is 0 gives `res_status` 3 (VIOL). It reports the index and address, and it still updates the LRU code.
- R6: A miss with `lk_update` 0 gives `res_status` 1 (MISS), with index and address 0, one cycle later. A miss with `lk_update` 1 raises `ut_req` for exactly one cycle, one cycle after acceptance, carrying the lookup address and ASID flag, and drops `lk_ready` until the reply. A hit never raises `ut_req`.
- R7: A reply with `rf_status` 0 writes the reply entry into the victim slot and answers like a hit on that slot one cycle later. The protection check uses the privilege level of the original lookup. A reply of code 1 or 3 gives MISS and leaves the entries unchanged.
- R8: The victim comes from `mmucr_i[31:26]`, sampled in the reply cycle. The first case that holds wins: entry 0 if bits 31, 30 and 29 are all 1; entry 1 if bits 31, 28, 27 are 0, 0, 1; entry 2 if bits 30, 28, 26 are 0, 0, 1; entry 3 if bits 29, 27, 26 are all 0. Otherwise entry 0.
- R9: Each OK or VIOL result comes with `mmucr_we` 1 in the same cycle. `mmucr_o` is `mmucr_i` from the deciding cycle with one change: entry 0 clears bits 31..29; entry 1 sets bit 31 and clears 28 and 27; entry 2 sets 30 and 28 and clears 26; entry 3 sets 29, 27 and 26. Bits 25..0 are unchanged.
- R10: Lookup requests presented while a unified-TLB reply is pending are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_use_asid | input | 1 | Enable ASID check |
| lk_update | input | 1 | Allow refill from the unified TLB on a miss |
| lk_priv | input | 1 | Fetch is privileged |
| cur_asid | input | 8 | Current ASID |
| mmucr_i | input | 32 | Present MMU control register value |
| ut_req | output | 1 | Unified-TLB lookup request pulse |
| ut_vaddr | output | 32 | Address for the unified-TLB lookup |
| ut_use_asid | output | 1 | ASID flag for the unified-TLB lookup |
| rf_valid | input | 1 | Unified-TLB reply valid |
| rf_status | input | 2 | Reply code: 0 entry, 1 miss, 2 multiple, 3 miss |
| rf_vpn | input | 22 | Reply entry virtual page number |
| rf_ppn | input | 22 | Reply entry physical page number |
| rf_size | input | 2 | Reply entry page size code |
| rf_asid | input | 8 | Reply entry ASID |
| rf_shared | input | 1 | Reply entry shared flag |
| rf_prot | input | 2 | Reply entry protection bits |
| res_valid | output | 1 | Result valid (one cycle) |
| res_status | output | 2 | 0 OK, 1 MISS, 2 MULTI, 3 VIOL |
| res_index | output | 2 | Entry index of the hit |
| res_paddr | output | 32 | Translated physical address |
| mmucr_we | output | 1 | Write strobe for the control register |
| mmucr_o | output | 32 | Control register value with LRU updated |

## Verification
The bench targets the page boundaries of each size code, one byte inside and one byte outside. A wrong mask there would turn the last byte into a miss or let the next page hit. It also covers ASID mismatches, both with and without the shared flag and with checking switched off. A design that ignored either flag would hit where it should miss.

The refill tests walk the LRU code from zero through all four victims. They then force a code where two cases hold, to check that the first one wins, and a code where none holds, to check the fall-back to entry 0. A priority or mask slip would overwrite a live entry, and a later overlap test would then show the wrong index or a missing multiple-hit. Lookups sent while a reply is pending must produce nothing.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    localparam int N_ENT      = 4;
    localparam int IDX_W      = $clog2(N_ENT);
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 10;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PPN_W      = 22;
    localparam int PA_W       = PPN_W + PAGE_SHIFT;
    localparam int ASID_W     = 8;
    localparam int CTL_W      = 32;
    localparam int LRU_W      = 6;
    localparam int LRU_LSB    = CTL_W - LRU_W;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic [ASID_W-1:0] asid;
        logic              shared;
        logic [1:0]        prot;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_MISS  = 2'd1,
        RES_MULTI = 2'd2,
        RES_VIOL  = 2'd3
    } res_t;

    localparam logic [1:0] UT_ENTRY = 2'd0;
    localparam logic [1:0] UT_MULTI = 2'd2;

    typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } fsm_t;

    // Byte-offset mask of a page for a given size code.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        int sh;
        case (sz)
            2'd0:    sh = 0;
            2'd1:    sh = 2;
            2'd2:    sh = 6;
            default: sh = 10;
        endcase
        return (VA_W'(1) << (PAGE_SHIFT + sh)) - VA_W'(1);
    endfunction

    // Replacement choice; c[5] corresponds to control bit 31, c[0] to bit 26.
    function automatic logic [IDX_W-1:0] lru_victim(input logic [LRU_W-1:0] c);
        if (c[5] && c[4] && c[3])
            return IDX_W'(0);
        else if (!c[5] && !c[2] && c[1])
            return IDX_W'(1);
        else if (!c[4] && !c[2] && c[0])
            return IDX_W'(2);
        else if (!c[3] && !c[1] && !c[0])
            return IDX_W'(3);
        else
            return IDX_W'(0);
    endfunction

    function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] c,
                                                   input logic [IDX_W-1:0] idx);
        logic [LRU_W-1:0] r;
        r = c;
        case (idx)
            2'd0: r[5:3] = 3'b000;
            2'd1: begin r[5] = 1'b1; r[2] = 1'b0; r[1] = 1'b0; end
            2'd2: begin r[4] = 1'b1; r[2] = 1'b1; r[0] = 1'b0; end
            default: begin r[3] = 1'b1; r[1] = 1'b1; r[0] = 1'b1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/itlb_cam.sv
module itlb_cam
    import itlb_pkg::*;
(
    input  tlb_ent_t [N_ENT-1:0] ents,
    input  logic [VA_W-1:0]      vaddr,
    input  logic                 use_asid,
    input  logic [ASID_W-1:0]    cur_asid,
    output logic                 hit_one,
    output logic                 hit_many,
    output logic [IDX_W-1:0]     hit_idx
);

    logic [N_ENT-1:0] hit_vec;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [VA_W-1:0] msk;
        logic            range_ok;
        logic            asid_ok;
        assign msk      = page_mask(ents[g].size);
        assign range_ok = (vaddr & ~msk) == ({ents[g].vpn, {PAGE_SHIFT{1'b0}}} & ~msk);
        assign asid_ok  = !use_asid || ents[g].shared || (ents[g].asid == cur_asid);
        assign hit_vec[g] = ents[g].valid && range_ok && asid_ok;
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i] && !found) begin
                hit_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign hit_many = $countones(hit_vec) > 1;
    assign hit_one  = $countones(hit_vec) == 1;

endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
    import itlb_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_in,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim,
    output logic [CTL_W-1:0] ctl_next
);

    logic [LRU_W-1:0] code;

    assign code     = ctl_in[CTL_W-1:LRU_LSB];
    assign victim   = lru_victim(code);
    assign ctl_next = {lru_touch(code, touch_idx), ctl_in[LRU_LSB-1:0]};

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
(
    input  tlb_ent_t         ent,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  paddr
);

    logic [VA_W-1:0] msk;

    assign msk   = page_mask(ent.size);
    assign paddr = ({ent.ppn, {PAGE_SHIFT{1'b0}}} & ~PA_W'(msk)) | PA_W'(vaddr & msk);

endmodule

// File: rtl/itlb_refill.sv
module itlb_refill
    import itlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [31:0]       lk_vaddr,
    input  logic              lk_use_asid,
    input  logic              lk_update,
    input  logic              lk_priv,
    input  logic [7:0]        cur_asid,
    input  logic [31:0]       mmucr_i,
    output logic              ut_req,
    output logic [31:0]       ut_vaddr,
    output logic              ut_use_asid,
    input  logic              rf_valid,
    input  logic [1:0]        rf_status,
    input  logic [21:0]       rf_vpn,
    input  logic [21:0]       rf_ppn,
    input  logic [1:0]        rf_size,
    input  logic [7:0]        rf_asid,
    input  logic              rf_shared,
    input  logic [1:0]        rf_prot,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [1:0]        res_index,
    output logic [31:0]       res_paddr,
    output logic              mmucr_we,
    output logic [31:0]       mmucr_o
);

    fsm_t                  state_q, state_d;
    tlb_ent_t [N_ENT-1:0]  ent_q, ent_d;
    logic [VA_W-1:0]       lat_va_q, lat_va_d;
    logic                  lat_ua_q, lat_ua_d;
    logic                  lat_priv_q, lat_priv_d;
    logic                  utreq_q, utreq_d;
    logic                  res_v_q, res_v_d;
    res_t                  res_st_q, res_st_d;
    logic [IDX_W-1:0]      res_idx_q, res_idx_d;
    logic [PA_W-1:0]       res_pa_q, res_pa_d;
    logic                  we_q, we_d;
    logic [CTL_W-1:0]      ctl_q, ctl_d;

    logic                  hit_one, hit_many;
    logic [IDX_W-1:0]      hit_idx;
    logic [IDX_W-1:0]      victim;
    logic [IDX_W-1:0]      touch_idx;
    logic [CTL_W-1:0]      ctl_next;
    tlb_ent_t              rf_ent;
    tlb_ent_t              sel_ent;
    logic [VA_W-1:0]       sel_va;
    logic [PA_W-1:0]       sel_pa;
    logic                  waiting;

    assign waiting = (state_q == ST_WAIT);

    always_comb begin
        rf_ent        = '0;
        rf_ent.valid  = 1'b1;
        rf_ent.vpn    = rf_vpn;
        rf_ent.ppn    = rf_ppn;
        rf_ent.size   = rf_size;
        rf_ent.asid   = rf_asid;
        rf_ent.shared = rf_shared;
        rf_ent.prot   = rf_prot;
    end

    itlb_cam u_cam (
        .ents     (ent_q),
        .vaddr    (lk_vaddr),
        .use_asid (lk_use_asid),
        .cur_asid (cur_asid),
        .hit_one  (hit_one),
        .hit_many (hit_many),
        .hit_idx  (hit_idx)
    );

    assign touch_idx = waiting ? victim : hit_idx;

    itlb_lru u_lru (
        .ctl_in    (mmucr_i),
        .touch_idx (touch_idx),
        .victim    (victim),
        .ctl_next  (ctl_next)
    );

    assign sel_ent = waiting ? rf_ent : ent_q[hit_idx];
    assign sel_va  = waiting ? lat_va_q : lk_vaddr;

    itlb_xlate u_xlate (
        .ent   (sel_ent),
        .vaddr (sel_va),
        .paddr (sel_pa)
    );

    always_comb begin
        state_d    = state_q;
        ent_d      = ent_q;
        lat_va_d   = lat_va_q;
        lat_ua_d   = lat_ua_q;
        lat_priv_d = lat_priv_q;
        utreq_d    = 1'b0;
        res_v_d    = 1'b0;
        res_st_d   = res_st_q;
        res_idx_d  = res_idx_q;
        res_pa_d   = res_pa_q;
        we_d       = 1'b0;
        ctl_d      = ctl_q;
        case (state_q)
            ST_IDLE: begin
                if (lk_valid) begin
                    if (hit_many) begin
                        res_v_d   = 1'b1;
                        res_st_d  = RES_MULTI;
                        res_idx_d = '0;
                        res_pa_d  = '0;
                    end else if (hit_one) begin
                        res_v_d   = 1'b1;
                        res_st_d  = (lk_priv && !ent_q[hit_idx].prot[1]) ? RES_VIOL : RES_OK;
                        res_idx_d = hit_idx;
                        res_pa_d  = sel_pa;
                        we_d      = 1'b1;
                        ctl_d     = ctl_next;
                    end else if (lk_update) begin
                        state_d    = ST_WAIT;
                        utreq_d    = 1'b1;
                        lat_va_d   = lk_vaddr;
                        lat_ua_d   = lk_use_asid;
                        lat_priv_d = lk_priv;
                    end else begin
                        res_v_d   = 1'b1;
                        res_st_d  = RES_MISS;
                        res_idx_d = '0;
                        res_pa_d  = '0;
                    end
                end
            end
            default: begin
                if (rf_valid) begin
                    state_d = ST_IDLE;
                    res_v_d = 1'b1;
                    if (rf_status == UT_ENTRY) begin
                        ent_d[victim] = rf_ent;
                        res_st_d  = (lat_priv_q && !rf_prot[1]) ? RES_VIOL : RES_OK;
                        res_idx_d = victim;
                        res_pa_d  = sel_pa;
                        we_d      = 1'b1;
                        ctl_d     = ctl_next;
                    end else if (rf_status == UT_MULTI) begin
                        res_st_d  = RES_MULTI;
                        res_idx_d = '0;
                        res_pa_d  = '0;
                    end else begin
                        res_st_d  = RES_MISS;
                        res_idx_d = '0;
                        res_pa_d  = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ent_q      <= '0;
            lat_va_q   <= '0;
            lat_ua_q   <= 1'b0;
            lat_priv_q <= 1'b0;
            utreq_q    <= 1'b0;
            res_v_q    <= 1'b0;
            res_st_q   <= RES_OK;
            res_idx_q  <= '0;
            res_pa_q   <= '0;
            we_q       <= 1'b0;
            ctl_q      <= '0;
        end else begin
            state_q    <= state_d;
            ent_q      <= ent_d;
            lat_va_q   <= lat_va_d;
            lat_ua_q   <= lat_ua_d;
            lat_priv_q <= lat_priv_d;
            utreq_q    <= utreq_d;
            res_v_q    <= res_v_d;
            res_st_q   <= res_st_d;
            res_idx_q  <= res_idx_d;
            res_pa_q   <= res_pa_d;
            we_q       <= we_d;
            ctl_q      <= ctl_d;
        end
    end

    assign lk_ready    = !waiting;
    assign ut_req      = utreq_q;
    assign ut_vaddr    = lat_va_q;
    assign ut_use_asid = lat_ua_q;
    assign res_valid   = res_v_q;
    assign res_status  = res_st_q;
    assign res_index   = res_idx_q;
    assign res_paddr   = res_pa_q;
    assign mmucr_we    = we_q;
    assign mmucr_o     = ctl_q;

endmodule

// File: rtl/itlb_chk.sv
module itlb_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_ready,
    input logic        ut_req,
    input logic        res_valid,
    input logic [1:0]  res_status,
    input logic [1:0]  res_index,
    input logic        mmucr_we,
    input logic [31:0] mmucr_i,
    input logic [31:0] mmucr_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !ut_req && !mmucr_we && lk_ready)); // R1

    AST_MULTI_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status == 2'd2) |-> !mmucr_we); // R4

    AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ut_req |-> !lk_ready); // R6

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        ut_req |=> !ut_req); // R6

    AST_WE_WITH_RES: assert property (@(posedge clk) disable iff (rst)
        mmucr_we |-> (res_valid && (res_status == 2'd0 || res_status == 2'd3))); // R9

    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        mmucr_we |-> (mmucr_o[25:0] == $past(mmucr_i[25:0]))); // R9

    AST_TOUCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mmucr_we && res_index == 2'd0) |-> (mmucr_o[31:29] == 3'b000)); // R9

    AST_TOUCH_THREE: assert property (@(posedge clk) disable iff (rst)
        (mmucr_we && res_index == 2'd3) |-> (mmucr_o[29] && mmucr_o[27] && mmucr_o[26])); // R9

endmodule

bind itlb_refill itlb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_ready   (lk_ready),
    .ut_req     (ut_req),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_index  (res_index),
    .mmucr_we   (mmucr_we),
    .mmucr_i    (mmucr_i),
    .mmucr_o    (mmucr_o)
);

// File: tb/itlb_refill_tb.sv
`timescale 1ns/1ps
module itlb_refill_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_ready;
    logic [31:0] lk_vaddr = '0;
    logic        lk_use_asid = 1'b0, lk_update = 1'b0, lk_priv = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic [31:0] mmucr_i = '0;
    logic        ut_req, ut_use_asid;
    logic [31:0] ut_vaddr;
    logic        rf_valid = 1'b0;
    logic [1:0]  rf_status = '0;
    logic [21:0] rf_vpn = '0, rf_ppn = '0;
    logic [1:0]  rf_size = '0;
    logic [7:0]  rf_asid = '0;
    logic        rf_shared = 1'b0;
    logic [1:0]  rf_prot = '0;
    logic        res_valid, mmucr_we;
    logic [1:0]  res_status, res_index;
    logic [31:0] res_paddr, mmucr_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    itlb_refill u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
        .lk_use_asid(lk_use_asid), .lk_update(lk_update), .lk_priv(lk_priv),
        .cur_asid(cur_asid), .mmucr_i(mmucr_i),
        .ut_req(ut_req), .ut_vaddr(ut_vaddr), .ut_use_asid(ut_use_asid),
        .rf_valid(rf_valid), .rf_status(rf_status), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_size(rf_size), .rf_asid(rf_asid), .rf_shared(rf_shared), .rf_prot(rf_prot),
        .res_valid(res_valid), .res_status(res_status), .res_index(res_index),
        .res_paddr(res_paddr), .mmucr_we(mmucr_we), .mmucr_o(mmucr_o)
    );

    // Behavioural reference state
    bit          m_v[4];
    int unsigned m_vpn[4], m_ppn[4], m_sz[4], m_asid[4];
    bit          m_sh[4];
    int unsigned m_pr[4];
    bit          m_wait;
    int unsigned m_va;
    bit          m_ua, m_priv;

    // Expected outputs after the coming edge
    bit          e_rv, e_we, e_utreq, e_ready;
    int unsigned e_st, e_idx, e_pa, e_mm, e_utva;
    bit          e_utua;

    function automatic int unsigned page_bytes(int unsigned sz);
        case (sz)
            0: return 1024;
            1: return 4096;
            2: return 65536;
            default: return 1048576;
        endcase
    endfunction

    function automatic int unsigned pick_victim(logic [31:0] m);
        if (m[31] == 1 && m[30] == 1 && m[29] == 1) return 0;
        if (m[31] == 0 && m[28] == 0 && m[27] == 1) return 1;
        if (m[30] == 0 && m[28] == 0 && m[26] == 1) return 2;
        if (m[29] == 0 && m[27] == 0 && m[26] == 0) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] touched(logic [31:0] m, int unsigned idx);
        logic [31:0] r = m;
        if (idx == 0) r = r & ~(32'h7 << 29);
        if (idx == 1) r = (r | (32'h1 << 31)) & ~(32'h3 << 27);
        if (idx == 2) r = (r | (32'h1 << 30) | (32'h1 << 28)) & ~(32'h1 << 26);
        if (idx == 3) r = r | (32'h1 << 29) | (32'h1 << 27) | (32'h1 << 26);
        return r;
    endfunction

    function automatic int unsigned xlate(int unsigned ppn, int unsigned sz, int unsigned va);
        int unsigned msk = page_bytes(sz) - 1;
        return ((ppn * 1024) & ~msk) | (va & msk);
    endfunction

    task automatic model_step();
        e_rv = 0; e_we = 0; e_utreq = 0;
        if (!m_wait && lk_valid) begin
            int cnt = 0;
            int idx = 0;
            for (int i = 3; i >= 0; i--) begin
                int unsigned msk = page_bytes(m_sz[i]) - 1;
                bit in_rng = ((lk_vaddr & ~msk) == ((m_vpn[i] * 1024) & ~msk));
                bit a_ok = !lk_use_asid || m_sh[i] || (m_asid[i] == cur_asid);
                if (m_v[i] && in_rng && a_ok) begin cnt++; idx = i; end
            end
            if (cnt > 1) begin
                e_rv = 1; e_st = 2; e_idx = 0; e_pa = 0;
            end else if (cnt == 1) begin
                e_rv = 1; e_idx = idx;
                e_st = (lk_priv && (m_pr[idx] & 2) == 0) ? 3 : 0;
                e_pa = xlate(m_ppn[idx], m_sz[idx], lk_vaddr);
                e_we = 1; e_mm = touched(mmucr_i, idx);
            end else if (lk_update) begin
                m_wait = 1; e_utreq = 1;
                m_va = lk_vaddr; m_ua = lk_use_asid; m_priv = lk_priv;
            end else begin
                e_rv = 1; e_st = 1; e_idx = 0; e_pa = 0;
            end
        end else if (m_wait && rf_valid) begin
            m_wait = 0; e_rv = 1;
            if (rf_status == 0) begin
                int unsigned v = pick_victim(mmucr_i);
                m_v[v] = 1; m_vpn[v] = rf_vpn; m_ppn[v] = rf_ppn; m_sz[v] = rf_size;
                m_asid[v] = rf_asid; m_sh[v] = rf_shared; m_pr[v] = rf_prot;
                e_idx = v;
                e_st = (m_priv && rf_prot[1] == 0) ? 3 : 0;
                e_pa = xlate(rf_ppn, rf_size, m_va);
                e_we = 1; e_mm = touched(mmucr_i, v);
            end else begin
                e_st = (rf_status == 2) ? 2 : 1; e_idx = 0; e_pa = 0;
            end
        end
        e_ready = !m_wait;
        e_utva = m_va; e_utua = m_ua;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "lk_ready", 32'(lk_ready), 32'(e_ready));
        chk(tag, "ut_req", 32'(ut_req), 32'(e_utreq));
        chk(tag, "res_valid", 32'(res_valid), 32'(e_rv));
        chk(tag, "mmucr_we", 32'(mmucr_we), 32'(e_we));
        if (e_utreq) begin
            chk(tag, "ut_vaddr", ut_vaddr, e_utva);
            chk(tag, "ut_use_asid", 32'(ut_use_asid), 32'(e_utua));
        end
        if (e_rv) begin
            chk(tag, "res_status", 32'(res_status), e_st);
            chk(tag, "res_index", 32'(res_index), e_idx);
            chk(tag, "res_paddr", res_paddr, e_pa);
        end
        if (e_we) chk(tag, "mmucr_o", mmucr_o, e_mm);
    endtask

    task automatic feedback();
        if (mmucr_we) mmucr_i = mmucr_o;
    endtask

    task automatic lookup(logic [31:0] va, bit ua, bit upd, bit priv, logic [7:0] asid, string tag);
        lk_valid = 1; lk_vaddr = va; lk_use_asid = ua; lk_update = upd;
        lk_priv = priv; cur_asid = asid;
        tick(tag);
        lk_valid = 0;
        feedback();
    endtask

    task automatic refill(logic [31:0] va, bit ua, bit priv, logic [7:0] asid,
                          logic [1:0] st, logic [21:0] vpn, logic [21:0] ppn,
                          logic [1:0] sz, logic [7:0] easid, bit sh, logic [1:0] pr,
                          string tag);
        lk_valid = 1; lk_vaddr = va; lk_use_asid = ua; lk_update = 1;
        lk_priv = priv; cur_asid = asid;
        tick("R6");
        // R10: a request during the pending reply must be dropped
        lk_vaddr = 32'h0040_0000; lk_update = 0; lk_use_asid = 0;
        tick("R10");
        lk_valid = 0;
        rf_valid = 1; rf_status = st; rf_vpn = vpn; rf_ppn = ppn; rf_size = sz;
        rf_asid = easid; rf_shared = sh; rf_prot = pr;
        tick(tag);
        rf_valid = 0;
        feedback();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_v[i] = 0;
        m_wait = 0; m_va = 0; m_ua = 0; m_priv = 0;
        repeat (3) @(negedge clk);
        chk("R1", "res_valid in reset", 32'(res_valid), 0);
        chk("R1", "ut_req in reset", 32'(ut_req), 0);
        chk("R1", "mmucr_we in reset", 32'(mmucr_we), 0);
        rst = 0;
        tick("R1");
        mmucr_i = 32'h0000_1234;
        lookup(32'h0040_0abc, 1, 0, 0, 8'd5, "R6");
        // Fill from an all-zero LRU code: victims 3, 1, 2, 0 follow
        refill(32'h0040_0abc, 1, 0, 8'd5, 2'd0, 22'h01000, 22'h12345, 2'd1, 8'd5, 0, 2'b10, "R7");
        refill(32'h1000_1234, 1, 0, 8'd7, 2'd0, 22'h40000, 22'h0AAAA, 2'd2, 8'd7, 1, 2'b11, "R8");
        refill(32'h2000_0010, 1, 1, 8'd5, 2'd0, 22'h80000, 22'h00333, 2'd3, 8'd5, 0, 2'b00, "R5");
        refill(32'h0000_0400, 0, 0, 8'd0, 2'd0, 22'h00001, 22'h3FFFF, 2'd0, 8'd9, 0, 2'b10, "R9");
        lookup(32'h0040_0fff, 1, 0, 0, 8'd5, "R2");
        lookup(32'h0040_1000, 1, 0, 0, 8'd5, "R2");
        lookup(32'h0040_0100, 1, 0, 0, 8'd6, "R3");
        lookup(32'h0040_0100, 0, 0, 0, 8'd6, "R3");
        lookup(32'h1000_fff0, 1, 0, 0, 8'd3, "R3");
        lookup(32'h1001_0000, 0, 0, 0, 8'd3, "R2");
        lookup(32'h2008_0000, 0, 1, 0, 8'd0, "R5");
        lookup(32'h2008_0000, 0, 0, 0, 8'd0, "R2");
        lookup(32'h0000_07ff, 0, 0, 0, 8'd0, "R2");
        lookup(32'h0000_0800, 0, 0, 0, 8'd0, "R2");
        lookup(32'h200f_fff0, 1, 1, 0, 8'd5, "R6");
        // Two cases hold for code 000011; the earlier one (entry 1) must win
        mmucr_i = {6'b000011, 26'h155_5555};
        refill(32'h0040_0200, 1, 0, 8'd6, 2'd0, 22'h01000, 22'h00777, 2'd1, 8'd6, 0, 2'b10, "R8");
        lookup(32'h0040_0200, 0, 0, 0, 8'd0, "R4");
        lookup(32'h0040_0200, 1, 0, 0, 8'd6, "R3");
        // No case holds for code 110010: fall back to entry 0
        mmucr_i = {6'b110010, 26'h2AB_CDEF};
        refill(32'h3000_0004, 0, 0, 8'd0, 2'd0, 22'hC0000, 22'h2_0000, 2'd2, 8'd1, 0, 2'b11, "R8");
        lookup(32'h3000_fffc, 0, 0, 0, 8'd0, "R8");
        lookup(32'h0000_0400, 0, 0, 0, 8'd0, "R8");
        refill(32'h5000_0000, 1, 0, 8'd2, 2'd1, 22'h0, 22'h0, 2'd0, 8'd0, 0, 2'b00, "R7");
        refill(32'h5000_0000, 1, 0, 8'd2, 2'd3, 22'h0, 22'h0, 2'd0, 8'd0, 0, 2'b00, "R7");
        refill(32'h5000_0000, 1, 0, 8'd2, 2'd2, 22'h0, 22'h0, 2'd0, 8'd0, 0, 2'b00, "R4");
        lookup(32'h5000_0000, 0, 0, 0, 8'd0, "R7");
        lookup(32'h1000_0000, 0, 0, 0, 8'd0, "R9");
        lookup(32'h2000_0000, 0, 0, 0, 8'd0, "R9");
        tick("R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule